// File: doc/BRIEF.md
# Single-Slot PCM Serial Port (Slave)

This block is the slave end of a framed serial voice link that carries one 8-bit PCM word in each direction per frame. An external bit clock, a frame strobe and a receive line arrive unsynchronised. The block oversamples them with a faster system clock and drives a transmit line that has a separate output enable, so a pad or a shared bus can leave it floating outside the block's time slot. Both directions use the same slot, which configuration places in either the first or the second bearer position of the frame.

On the parallel side a producer writes the next outgoing word into a holding register. A consumer receives each incoming word with a one-cycle valid pulse. A sticky error flag reports frames that start too early and a bit clock or frame strobe that has stopped. The transmit path is a valid/ready sink. `tx_ready_o` is always high, so there is never back-pressure, and a later write replaces an earlier one that has not yet been sent. The receive path is a valid-only source with no ready, because the serial line cannot be stalled. A consumer must take `rx_data_o` when `rx_valid_o` is high, although the value stays in place until the next word arrives.

Top module: `pcm_idl_slave`

## Requirements
- R1: While reset is applied and after it is released, `txd_oe_o`, `rx_valid_o` and `frame_err_o` are 0, `rx_data_o` is 0 and `tx_ready_o` is 1.
- R2: A frame begins on a bit-clock falling edge at which the strobe is high, and `chan_sel_i` is latched at that edge. Counting bit-clock rising edges after it from 1, channel 0 occupies edges 1 to 8 and channel 1 occupies edges 10 to 17.
- R3: `txd_oe_o` goes high on the rising edge that opens the slot's first bit and goes low on the falling edge that closes its eighth bit. It is low at every other time.
- R4: The holding register is copied into the transmit shifter at the slot's first rising edge. The word is sent most significant bit first and changes on rising edges.
- R5: If nothing is written between two slots, the same word is sent again.
- R6: Receive bits are sampled on the slot's falling edges, most significant bit first. After the eighth bit, `rx_valid_o` is high for exactly one system clock, and `rx_data_o` then holds the word until the next one arrives.
- R7: A frame start that arrives before the previous frame's slot has finished sets `frame_err_o`, and the flag stays set until reset. The new frame is muted: there is no output enable and no receive pulse. A later frame start that arrives after the muted frame's slot window has passed brings back normal operation.
- R8: If no new frame start arrives within `TIMEOUT_CYCLES` system clocks of the last one, `frame_err_o` is set and `txd_oe_o` is released at once. The next frame start is treated as clean.
- R9: Every cycle with `tx_valid_i` high writes `tx_data_i` into the holding register, and the last write before a slot's first rising edge is the word sent.
- R10: Each response appears on the third system-clock rising edge, counting from the first edge that samples the external input's change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_sel_i | input | 1 | Slot choice, 0 first bearer, 1 second bearer; latched at frame start |
| bclk_i | input | 1 | External bit clock (asynchronous) |
| fsync_i | input | 1 | External frame strobe (asynchronous) |
| rxd_i | input | 1 | Serial receive data (asynchronous) |
| txd_o | output | 1 | Serial transmit data, 0 when not enabled |
| txd_oe_o | output | 1 | Output enable for the transmit pad |
| tx_data_i | input | WORD_W | Word to be sent |
| tx_valid_i | input | 1 | Write strobe for `tx_data_i` |
| tx_ready_o | output | 1 | Always 1; writes are never refused |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when a word is received |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
Words are exchanged in both slot positions using patterns that are all zeros, all ones, alternating, and a single set bit at either end. These patterns expose bit-order reversal, a slot that is off by one, and a stuck line. Frames with no write in between check retransmission, and back-to-back writes check which write wins. A frame cut short by an early strobe checks the sticky flag, the muted frame, and recovery on the frame after it. A bit clock that stops in the middle of a slot checks the timeout and the immediate release of the enable.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic {
    CH_FIRST  = 1'b0,
    CH_SECOND = 1'b1
  } chan_e;

  typedef struct packed {
    logic load;   // copy holding register, present MSB
    logic shift;  // advance transmit shifter
    logic cap;    // sample receive bit
    logic last;   // eighth receive bit
  } slot_ev_t;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int N_DATA = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_raw,
  input  logic [N_DATA-1:0] data_raw,
  output logic              bclk_rise,
  output logic              bclk_fall,
  output logic [N_DATA-1:0] data_s
);
  logic [STAGES:0] bclk_chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_chain <= '0;
    else        bclk_chain <= {bclk_chain[STAGES-1:0], bclk_raw};
  end

  assign bclk_rise = bclk_chain[STAGES-1] & ~bclk_chain[STAGES];
  assign bclk_fall = ~bclk_chain[STAGES-1] & bclk_chain[STAGES];

  for (genvar i = 0; i < N_DATA; i++) begin : g_data
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], data_raw[i]};
    end
    assign data_s[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_pkg::*;
#(
  parameter int WORD_W         = 8,
  parameter int FIRST_POS_A    = 1,
  parameter int FIRST_POS_B    = 10,
  parameter int TIMEOUT_CYCLES = 20000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bclk_rise,
  input  logic     bclk_fall,
  input  logic     sync_lvl,
  input  logic     chan_sel,
  output slot_ev_t ev,
  output logic     oe,
  output logic     err
);
  localparam int MAX_POS = FIRST_POS_B + WORD_W - 1;
  localparam int CNT_W   = $clog2(MAX_POS + 2);
  localparam int TO_W    = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             active_q, mute_q, done_q;
  chan_e            chan_q;
  logic [CNT_W-1:0] rcnt_q, rnext, first_pos, last_pos;
  logic [TO_W-1:0]  tcnt_q;
  logic             sync_ev, early, timeout_hit, win_next, win_cur, live;

  assign first_pos   = (chan_q == CH_SECOND) ? CNT_W'(FIRST_POS_B) : CNT_W'(FIRST_POS_A);
  assign last_pos    = first_pos + CNT_W'(WORD_W - 1);
  assign rnext       = (rcnt_q == CNT_SAT) ? rcnt_q : rcnt_q + 1'b1;
  assign win_next    = (rnext >= first_pos) && (rnext <= last_pos);
  assign win_cur     = (rcnt_q >= first_pos) && (rcnt_q <= last_pos);
  assign sync_ev     = bclk_fall & sync_lvl;
  assign early       = active_q & ~done_q;
  assign timeout_hit = active_q & ~sync_ev & (tcnt_q == TO_W'(TIMEOUT_CYCLES - 1));
  assign live        = active_q & ~mute_q & ~timeout_hit;

  always_comb begin
    ev.load  = live & bclk_rise & (rnext == first_pos);
    ev.shift = live & bclk_rise & win_next & (rnext != first_pos);
    ev.cap   = live & bclk_fall & ~sync_lvl & win_cur;
    ev.last  = ev.cap & (rcnt_q == last_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mute_q   <= 1'b0;
      done_q   <= 1'b0;
      chan_q   <= CH_FIRST;
      rcnt_q   <= '0;
      tcnt_q   <= '0;
      oe       <= 1'b0;
      err      <= 1'b0;
    end else if (sync_ev) begin
      active_q <= 1'b1;
      mute_q   <= early;
      err      <= err | early;
      done_q   <= 1'b0;
      chan_q   <= chan_e'(chan_sel);
      rcnt_q   <= '0;
      tcnt_q   <= '0;
      oe       <= 1'b0;
    end else if (timeout_hit) begin
      active_q <= 1'b0;
      err      <= 1'b1;
      tcnt_q   <= '0;
      oe       <= 1'b0;
    end else if (active_q) begin
      tcnt_q <= tcnt_q + 1'b1;
      if (bclk_rise) rcnt_q <= rnext;
      if (ev.load) oe <= 1'b1;
      if (bclk_fall && win_cur && rcnt_q == last_pos) begin
        done_q <= 1'b1;
        oe     <= 1'b0;
      end
    end
  end

  a_r3_oe_opens_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(bclk_rise));
  a_r3_oe_closes_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> ($past(bclk_fall) || err));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r7_muted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q |-> !oe);
endmodule

// File: rtl/pcm_shift_path.sv
module pcm_shift_path
  import pcm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ev_t          ev,
  input  logic              rxd_lvl,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tx_bit,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_pulse
);
  logic [WORD_W-1:0] hold_q, tsh_q, rsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      tsh_q    <= '0;
      rsh_q    <= '0;
      rx_word  <= '0;
      rx_pulse <= 1'b0;
    end else begin
      rx_pulse <= 1'b0;
      if (wr_en)         hold_q <= wr_data;
      if (ev.load)       tsh_q  <= hold_q;
      else if (ev.shift) tsh_q  <= {tsh_q[WORD_W-2:0], 1'b0};
      if (ev.cap) rsh_q <= {rsh_q[WORD_W-2:0], rxd_lvl};
      if (ev.last) begin
        rx_word  <= {rsh_q[WORD_W-2:0], rxd_lvl};
        rx_pulse <= 1'b1;
      end
    end
  end

  assign tx_bit = tsh_q[WORD_W-1];

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |=> !rx_pulse);
  a_r6_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |-> $past(ev.last));
endmodule

// File: rtl/pcm_idl_slave.sv
module pcm_idl_slave
  import pcm_pkg::*;
#(
  parameter int WORD_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int FIRST_POS_A    = 1,
  parameter int FIRST_POS_B    = 10,
  parameter int TIMEOUT_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_sel_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              txd_oe_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              frame_err_o
);
  logic       bclk_rise, bclk_fall, tx_bit;
  logic [1:0] data_s;
  slot_ev_t   ev;

  pcm_in_sync #(.N_DATA(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_raw  (bclk_i),
    .data_raw  ({fsync_i, rxd_i}),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .data_s    (data_s)
  );

  pcm_slot_ctrl #(
    .WORD_W(WORD_W), .FIRST_POS_A(FIRST_POS_A),
    .FIRST_POS_B(FIRST_POS_B), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .sync_lvl  (data_s[1]),
    .chan_sel  (chan_sel_i),
    .ev        (ev),
    .oe        (txd_oe_o),
    .err       (frame_err_o)
  );

  pcm_shift_path #(.WORD_W(WORD_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .rxd_lvl  (data_s[0]),
    .wr_en    (tx_valid_i),
    .wr_data  (tx_data_i),
    .tx_bit   (tx_bit),
    .rx_word  (rx_data_o),
    .rx_pulse (rx_valid_o)
  );

  assign tx_ready_o = 1'b1;
  assign txd_o      = txd_oe_o & tx_bit;
endmodule

// File: tb/pcm_idl_slave_tb_top.sv
`timescale 1ns/1ps
module pcm_idl_slave_tb_top;
  localparam int TO = 600;
  localparam int H  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_sel = 1'b0, bclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic txd, txd_oe, tx_ready, rx_valid, frame_err;
  logic [7:0] rx_data;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pcm_idl_slave #(.TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_sel_i(chan_sel), .bclk_i(bclk),
    .fsync_i(fsync), .rxd_i(rxd), .txd_o(txd), .txd_oe_o(txd_oe),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .frame_err_o(frame_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, 3-sample input history (R10)
  logic [2:0] hist[$];
  bit m_active, m_mute, m_done, m_chan, m_oe, m_err, m_rxv;
  int m_r, m_t;
  logic [7:0] m_hold, m_tsh, m_rsh, m_rxd;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_active = 0; m_mute = 0; m_done = 0; m_chan = 0; m_oe = 0; m_err = 0; m_rxv = 0;
      m_r = 0; m_t = 0; m_hold = 0; m_tsh = 0; m_rsh = 0; m_rxd = 0;
    end else begin
      logic [2:0] cur, prv;
      bit rise, fall;
      int first, last;
      hist.push_back({bclk, fsync, rxd});
      void'(hist.pop_front());
      cur = hist[1]; prv = hist[0];
      rise = cur[2] && !prv[2];
      fall = !cur[2] && prv[2];
      m_rxv = 0;
      first = m_chan ? 10 : 1;
      last = first + 7;
      if (fall && cur[1]) begin
        if (m_active && !m_done) m_err = 1;
        m_mute = m_active && !m_done;
        m_active = 1; m_r = 0; m_done = 0; m_chan = chan_sel; m_oe = 0; m_t = 0;
      end else if (m_active && m_t == TO - 1) begin
        m_active = 0; m_oe = 0; m_err = 1; m_t = 0;
      end else if (m_active) begin
        m_t++;
        if (rise) begin
          if (m_r < 31) m_r++;
          if (!m_mute && m_r == first) begin m_tsh = m_hold; m_oe = 1; end
          else if (!m_mute && m_r > first && m_r <= last) m_tsh = m_tsh << 1;
        end
        if (fall && m_r >= first && m_r <= last) begin
          if (!m_mute) m_rsh = {m_rsh[6:0], cur[0]};
          if (m_r == last) begin
            m_done = 1; m_oe = 0;
            if (!m_mute) begin m_rxd = m_rsh; m_rxv = 1; end
          end
        end
      end
      if (tx_valid) m_hold = tx_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 oe vs model", txd_oe, m_oe);
      if (m_oe) chk("R4 txd vs model", txd, m_tsh[7]);
      chk("R6 rx_valid vs model", rx_valid, m_rxv);
      chk("R6 rx_data vs model", rx_data, m_rxd);
      chk("R7 frame_err vs model", frame_err, m_err);
      chk("R9 tx_ready high", tx_ready, 1'b1);
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bclk = 0; fsync = 0; rxd = 0;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", txd_oe, 0);
    chk("R1 err in reset", frame_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe", txd_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 err", frame_err, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 ready", tx_ready, 1);
  endtask

  task automatic run_frame(input int nclk, input logic [7:0] rxw,
                           output logic [7:0] txw, output int oe_cnt);
    int fc;
    fc = chan_sel ? 11 : 2;
    txw = '0; oe_cnt = 0;
    for (int c = 1; c <= nclk; c++) begin
      @(negedge clk);
      bclk = 1; fsync = (c == 1);
      rxd = (c >= fc && c <= fc + 7) ? rxw[7 - (c - fc)] : 1'b0;
      repeat (H) @(negedge clk);
      if (c >= fc && c <= fc + 7) begin
        txw[7 - (c - fc)] = txd;
        if (txd_oe) oe_cnt++;
      end
      bclk = 0;
      repeat (H) @(negedge clk);
      if (c == 1) fsync = 0;
    end
  endtask

  task automatic good_frame(input logic [7:0] rxw, input logic [7:0] exp_tx, input string tag);
    logic [7:0] txw; int n;
    run_frame(20, rxw, txw, n);
    chk({tag, " tx word"}, txw, exp_tx);
    chk("R3 oe bit-times", n, 8);
    chk("R3 oe low after slot", txd_oe, 0);
    chk("R6 rx word", rx_data, rxw);
  endtask

  initial begin
    logic [7:0] w; int n;
    do_reset();
    // R2 channel 0 slot
    wr(8'hA5); good_frame(8'h3C, 8'hA5, "R4 B1");
    good_frame(8'hC3, 8'hA5, "R5 repeat");
    wr(8'h11); wr(8'hE7); good_frame(8'h00, 8'hE7, "R9 last write");
    wr(8'h01); good_frame(8'hFF, 8'h01, "R4 lsb only");
    // R2 channel 1 slot
    chan_sel = 1;
    wr(8'h5A); good_frame(8'h80, 8'h5A, "R2 B2");
    wr(8'h80); good_frame(8'h01, 8'h80, "R2 B2 msb");
    chk("R7 no error yet", frame_err, 0);
    // R7 early frame start
    chan_sel = 0;
    wr(8'h69);
    run_frame(6, 8'hF0, w, n);
    run_frame(20, 8'h0F, w, n);
    chk("R7 err set", frame_err, 1);
    chk("R7 muted oe", n, 0);
    good_frame(8'h96, 8'h69, "R7 recover");
    chk("R7 err sticky", frame_err, 1);
    // R8 timeout with clock stopped mid-slot
    do_reset();
    wr(8'hF0);
    run_frame(5, 8'hAA, w, n);
    chk("R3 oe mid-slot", txd_oe, 1);
    repeat (TO + 100) @(negedge clk);
    chk("R8 err after timeout", frame_err, 1);
    chk("R8 oe released", txd_oe, 0);
    wr(8'h3C); good_frame(8'h55, 8'h3C, "R8 clean after timeout");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule